// File: doc/BRIEF.md
# Framed Serial Register Write Port

This block is a write-only serial slave that accepts 16-bit command words from an external host over a three-wire link. The link has a serial clock, a serial data line and an active-low frame strobe. The strobe serves both as frame synchronisation and as chip enable. While the strobe is low, the block samples one data bit on each falling edge of the serial clock, most significant bit first. After sixteen bits it treats the group as one complete word. A host may hold the strobe low for any whole number of words and stream them back to back. It may also raise the strobe after each word.

Each completed word crosses into the core clock domain through a toggle handshake. It then appears as a one-cycle write strobe that carries the full word. The strobe also carries the 2-bit destination code taken from the word's two leading bits, and a flag that marks a control-register write (code 00). Any words still arriving in the serial domain do not disturb a word that is being handed over.

Top module: `ser_wr_port`

## Requirements
- R1: While and after core reset, `wr_valid` is 0 until a complete word has been received.
- R2: With `fsync_n` low, `sdi` is sampled on each falling edge of `sck`, first bit received becomes bit 15, and `wr_word` equals the 16 sampled bits.
- R3: `wr_dest` equals `wr_word[15:14]`, and `wr_ctrl` is 1 exactly when that code is 2'b00.
- R4: Each completed word produces exactly one `wr_valid` pulse, one core cycle wide, and `wr_word` changes only in a cycle where `wr_valid` is 1.
- R5: If `fsync_n` rises after fewer than 16 falling edges, no pulse is issued, and the next frame starts from bit 15 again.
- R6: With `fsync_n` held low for N×16 falling edges, N words are delivered in order.
- R7: Falling edges of `sck` while `fsync_n` is high change nothing at the outputs.
- R8: Whether `sck` idles high or low between frames, the frames are received the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous core reset |
| sck | input | 1 | Serial clock; data taken on falling edges |
| sdi | input | 1 | Serial data, MSB first |
| fsync_n | input | 1 | Active-low frame strobe and enable |
| wr_valid | output | 1 | One-cycle write strobe in the core domain |
| wr_word | output | 16 | Received word |
| wr_dest | output | 2 | Destination code from the word's top bits |
| wr_ctrl | output | 1 | High when the destination is the control register |

## Verification
Two events can fall on the same core cycle. One is the handover of a finished word through the synchroniser. The other is the serial side shifting the first bits of the following word in the same held-low frame. The bench provokes this with streams of up to three words under one frame, with no gap between them. It judges the result by comparing each pulse's word, destination and flag against a queue of the words sent. Random frames also truncate words and change the idle level of `sck`, so a lost, duplicated or misaligned word shows up as a queue mismatch.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;
    localparam int WORD_W = 16;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        DEST_CTRL = 2'b00,
        DEST_A    = 2'b01,
        DEST_B    = 2'b10,
        DEST_C    = 2'b11
    } dest_e;
endpackage

// File: rtl/ser_wr_shift.sv
module ser_wr_shift #(
    parameter int WORD_W = 16
) (
    input  logic              sck,
    input  logic              sdi,
    input  logic              fsync_n,
    input  logic              rst_n,
    output logic [WORD_W-1:0] hold_o,
    output logic              tog_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } frame_t;

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              tog;
    } out_t;

    frame_t fr_d, fr_q;
    out_t   out_d, out_q;
    logic   done;

    always_comb begin
        fr_d   = fr_q;
        out_d  = out_q;
        fr_d.sh = {fr_q.sh[WORD_W-2:0], sdi};
        done    = (fr_q.cnt == LAST);
        fr_d.cnt = done ? '0 : fr_q.cnt + 1'b1;
        if (done) begin
            out_d.hold = fr_d.sh;
            out_d.tog  = ~out_q.tog;
        end
    end

    // frame strobe high holds the counter and shifter cleared
    always_ff @(negedge sck or posedge fsync_n) begin
        if (fsync_n) fr_q <= '0;
        else         fr_q <= fr_d;
    end

    always_ff @(negedge sck or negedge rst_n) begin
        if (!rst_n)        out_q <= '0;
        else if (!fsync_n) out_q <= out_d;
    end

    assign hold_o = out_q.hold;
    assign tog_o  = out_q.tog;
endmodule

// File: rtl/ser_wr_sync.sv
module ser_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              seen;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], tog_i};
        s_d.seen  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.chain[STAGES-1] ^ s_q.seen;
endmodule

// File: rtl/ser_wr_decode.sv
module ser_wr_decode
    import ser_wr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output dest_e             dest_o,
    output logic              ctrl_o
);
    always_comb begin
        dest_o = dest_e'(word_i[WORD_W-1 -: SEL_W]);
        ctrl_o = (dest_o == DEST_CTRL);
    end
endmodule

// File: rtl/ser_wr_port.sv
module ser_wr_port
    import ser_wr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              fsync_n,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_word,
    output logic [SEL_W-1:0]  wr_dest,
    output logic              wr_ctrl
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic [SEL_W-1:0]  dest;
        logic              ctrl;
    } core_t;

    logic [WORD_W-1:0] hold;
    logic              tog;
    logic              pulse;
    dest_e             dec_dest;
    logic              dec_ctrl;
    core_t             c_d, c_q;

    ser_wr_shift #(.WORD_W(WORD_W)) u_shift (
        .sck(sck), .sdi(sdi), .fsync_n(fsync_n), .rst_n(rst_n),
        .hold_o(hold), .tog_o(tog)
    );

    ser_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tog_i(tog), .pulse_o(pulse)
    );

    ser_wr_decode #(.WORD_W(WORD_W)) u_dec (
        .word_i(hold), .dest_o(dec_dest), .ctrl_o(dec_ctrl)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = pulse;
        if (pulse) begin
            c_d.word = hold;
            c_d.dest = dec_dest;
            c_d.ctrl = dec_ctrl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign wr_valid = c_q.valid;
    assign wr_word  = c_q.word;
    assign wr_dest  = c_q.dest;
    assign wr_ctrl  = c_q.ctrl;
endmodule

// File: rtl/ser_wr_port_chk.sv
module ser_wr_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic [15:0] wr_word,
    input logic [1:0]  wr_dest,
    input logic        wr_ctrl
);
    always @(posedge clk) begin
        if (!rst_n) a_r1_idle_in_reset: assert (!wr_valid);
    end

    a_r3_dest_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_dest == wr_word[15:14]);

    a_r3_ctrl_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_ctrl == (wr_dest == 2'b00));

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (wr_valid || $stable(wr_word)));
endmodule

bind ser_wr_port ser_wr_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_word(wr_word), .wr_dest(wr_dest), .wr_ctrl(wr_ctrl)
);

// File: tb/ser_wr_port_test.sv
module ser_wr_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        sck = 0;
    logic        sdi = 0;
    logic        fsync_n = 1;
    logic        wr_valid;
    logic [15:0] wr_word;
    logic [1:0]  wr_dest;
    logic        wr_ctrl;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    logic prev_valid = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ser_wr_port uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .fsync_n(fsync_n),
        .wr_valid(wr_valid), .wr_word(wr_word), .wr_dest(wr_dest), .wr_ctrl(wr_ctrl)
    );

    function automatic logic [1:0] exp_dest(input logic [15:0] w);
        return w[15:14];
    endfunction

    function automatic logic exp_ctrl(input logic [15:0] w);
        return w[15:14] == 2'b00;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && prev_valid)
                check(0, "R4 pulse wider than one cycle", 32'd2, 32'd1);
            if (wr_valid && !prev_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4/R5/R7 unexpected pulse", {16'h0, wr_word}, 32'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(wr_word == e, "R2/R6 word", {16'h0, wr_word}, {16'h0, e});
                    check(wr_dest == exp_dest(e), "R3 dest", {30'h0, wr_dest}, {30'h0, exp_dest(e)});
                    check(wr_ctrl == exp_ctrl(e), "R3 ctrl", {31'h0, wr_ctrl}, {31'h0, exp_ctrl(e)});
                end
            end
            prev_valid <= wr_valid;
        end
    end

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) begin
            sck = 1; sdi = w[i]; #16;
            sck = 0; #16;
        end
    endtask

    task automatic frame(input logic [15:0] words[3], input int nw, input int tail, input bit idle_hi);
        fsync_n = 0; #16;
        for (int k = 0; k < nw; k++) begin
            send_bits(words[k], 16);
            exp_q.push_back(words[k]);
        end
        if (tail > 0) send_bits(16'hFFFF, tail);
        #16 fsync_n = 1;
        sck = idle_hi; #16;
    endtask

    task automatic drain(input string req);
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        logic [15:0] ws[3];
        void'($urandom(32'h1234_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_valid == 0, "R1 reset valid", {31'h0, wr_valid}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(wr_valid == 0, "R1 idle after reset", {31'h0, wr_valid}, 0);

        // R2/R3: control word and each destination code
        ws[0] = 16'h2ABC; frame(ws, 1, 0, 0); drain("R3 ctrl word delivered");
        ws[0] = 16'h4001; frame(ws, 1, 0, 0); drain("R3 dest 01 delivered");
        ws[0] = 16'h8000; frame(ws, 1, 0, 1); drain("R8 idle high delivered");
        ws[0] = 16'hC5A5; frame(ws, 1, 0, 0); drain("R3 dest 11 delivered");

        // R5: truncated word, then a full word restarts at bit 15
        ws[0] = 16'h0; frame(ws, 0, 9, 0); drain("R5 partial discarded");
        ws[0] = 16'h1357; frame(ws, 1, 0, 0); drain("R5 restart after partial");

        // R6: three words in one held-low frame
        ws[0] = 16'h0001; ws[1] = 16'hFFFE; ws[2] = 16'h6A6A;
        frame(ws, 3, 0, 1); drain("R6 stream of three");

        // R7: clocks while the strobe is high
        for (int i = 0; i < 20; i++) begin
            sck = 1; sdi = 1'($urandom); #16; sck = 0; #16;
        end
        drain("R7 no pulse with strobe high");
        ws[0] = 16'h3C3C; frame(ws, 1, 0, 0); drain("R7 clean word after");

        // random frames
        for (int f = 0; f < 25; f++) begin
            int nw;
            int tail;
            nw = 1 + int'($urandom_range(2, 0));
            tail = ($urandom_range(3, 0) == 0) ? int'($urandom_range(15, 1)) : 0;
            for (int k = 0; k < 3; k++) ws[k] = 16'($urandom);
            frame(ws, nw, tail, 1'($urandom));
            drain("R6/R8 random frame");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule